// File: doc/BRIEF.md
# Reaction Timer Controller

This block measures how quickly a person responds to a light, in milliseconds. Pressing the reset pushbutton clears the block. Releasing it starts a wait whose length, in milliseconds, comes from an 8-bit setting. When the wait ends, the indicator LED turns on and a four-digit decimal millisecond count starts from zero. When the person presses the stop pushbutton, the LED turns off and the count freezes. The count stays on the displays until the reset pushbutton is pressed again.

Every flip-flop runs on the single system clock (50 MHz by default). A prescaler makes a one-cycle enable pulse each millisecond; it does not make a new clock. Both pushbuttons are active-low and may change at any time relative to the clock, so each passes through a two-stage synchronizer before the control logic uses it. The count is kept directly as four BCD digits, and each digit also drives a seven-segment pattern.

Top module: `reaction_timer`

## Requirements
- R1: While `rst_n` is low, or while the synchronized reset pushbutton is held, the LED is off and all four BCD digits read 0; the state is reached within three clock cycles of the press.
- R2: With a setting D of 1 to 255, the LED turns on exactly 3 + D*P clock edges after the first edge that samples the released reset pushbutton. Here P is `CLK_PER_MS`; the 3 cycles are two synchronizer stages and one state cycle.
- R3: A setting of 0 acts like a setting of 1: the LED turns on at the first millisecond tick, 3 + P edges after release.
- R4: While the LED is on, the count starts at 0000 and rises by one each P clock cycles, with the first step P edges after the LED turns on. The count is cascaded BCD: `bcd_digits[4i+3:4i]` is digit i (digit 0 is the units digit), each digit runs 0 to 9, and a digit carries into the next when it wraps.
- R5: A stop press while the LED is on turns the LED off and freezes the count three cycles after the press reaches the pins. A press made X = R*P cycles after the LED turns on (with P of at least 4) freezes the count at R.
- R6: Once frozen, the count and the dark LED hold through further stop presses and changes of the delay setting, until a reset press clears them.
- R7: A stop press during the wait is ignored: the LED still turns on at the time given by R2, and the count still starts from 0000.
- R8: If stop is never pressed, the count saturates at 9999 and stays there with the LED on.
- R9: `seg_out[7i+6:7i]` is the active-high pattern for digit i, with bit 0 = segment a through bit 6 = segment g. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz by default |
| rst_n | input | 1 | Synchronous active-low system reset |
| btn_reset_n | input | 1 | Reset pushbutton, active-low, asynchronous to `clk` |
| btn_stop_n | input | 1 | Stop pushbutton, active-low, asynchronous to `clk` |
| delay_ms | input | 8 | Wait before the LED turns on, in milliseconds (unsigned) |
| led | output | 1 | Indicator LED, high while the measurement runs |
| bcd_digits | output | 16 | Four BCD digits of the count; digit 0 is in bits 3:0 |
| seg_out | output | 28 | Four seven-segment patterns, 7 bits per digit |

## Verification
The control state shows up at the pins almost at once. A state that entered the run phase too early or too late moves the LED's rising edge away from its exact cycle, at 3 + max(D,1)*P edges after release. A stop press that slipped through during the wait shows up as a missing LED pulse. A prescaler that miscounts shows up as a frozen count different from the number of milliseconds elapsed, within one millisecond of the error. A broken carry or saturation shows up in the BCD digits and segment patterns when a digit wraps, or after ten thousand milliseconds when the count must hold at 9999.

// File: rtl/rt_pkg.sv
// Package: shared types and helpers for the reaction timer.
// Assumes: seven-segment patterns are active-high, bit 0 = segment a.
package rt_pkg;

    // Control phases of a measurement
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // reset held: everything cleared
        PH_WAIT = 2'd1,   // counting down the programmed delay
        PH_RUN  = 2'd2,   // LED on, counting milliseconds
        PH_HALT = 2'd3    // count frozen until the next reset press
    } rt_phase_t;

    // Decode one BCD digit into its seven-segment pattern (g..a)
    function automatic logic [6:0] seg7_of(input logic [3:0] d);
        logic [6:0] p;
        case (d)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h40;   // dash for codes that are not BCD
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rt_sync.sv
// Module: rt_sync
// Multi-stage synchronizer for a bundle of slow asynchronous inputs.
// Assumes: the inputs are independent, level-type signals (pushbuttons);
// no bus coherency is implied across bits. Reset loads RESET_VAL.
module rt_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages: let a metastable value settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/rt_prescaler.sv
// Module: rt_prescaler
// Divides the system clock into a one-cycle enable pulse every DIV cycles.
// Assumes: clr holds the divider at zero, so the first pulse after clr
// drops comes DIV cycles later.
module rt_prescaler #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Cycle counter that wraps on the tick
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R4: the millisecond enable never lasts two cycles
            assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
            // R2: a cleared divider cannot tick on the next cycle
            assert_clr_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rt_bcd_counter.sv
// Module: rt_bcd_counter
// Cascaded BCD up-counter with saturation at all nines.
// Assumes: step is a one-cycle enable; clr has priority over step.
module rt_bcd_counter #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  step,
    output logic [4*DIGITS-1:0]   value
);

    logic [3:0]      dig_q [DIGITS];
    logic [DIGITS:0] carry;
    logic            all_nine;

    // Saturation detect: every digit already at 9
    always_comb begin
        all_nine = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (dig_q[i] != 4'd9) all_nine = 1'b0;
        end
    end

    assign carry[0] = step && !all_nine;

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_digit
            assign carry[i+1] = carry[i] && (dig_q[i] == 4'd9);

            // One decade: advance on carry-in, wrap 9 to 0
            always_ff @(posedge clk) begin
                if (!rst_n || clr)       dig_q[i] <= 4'd0;
                else if (carry[i])       dig_q[i] <= (dig_q[i] == 4'd9) ? 4'd0 : dig_q[i] + 4'd1;
            end

            assign value[4*i +: 4] = dig_q[i];

            // R4: a digit never leaves the decimal range
            assert_digit_decimal_R4: assert property (@(posedge clk) disable iff (!rst_n)
                dig_q[i] <= 4'd9);
        end
    endgenerate

    // R8: once all nines, the count holds until cleared
    assert_saturate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (all_nine && !clr) |=> $stable(value));

    // R6: without a step the count does not move
    assert_no_step_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(value));

endmodule

// File: rtl/rt_seg_bank.sv
// Module: rt_seg_bank
// Converts a row of BCD digits into seven-segment patterns, one per digit.
// Assumes: purely combinational; patterns are active-high.
module rt_seg_bank
    import rt_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] bcd,
    output logic [7*DIGITS-1:0] seg
);

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_seg
            assign seg[7*i +: 7] = seg7_of(bcd[4*i +: 4]);
        end
    endgenerate

endmodule

// File: rtl/rt_ctrl.sv
// Module: rt_ctrl
// Phase sequencer: idle, programmed wait, run, halt.
// Assumes: reset_req and stop_req are synchronized, active-high levels;
// tick is the one-cycle millisecond enable. A reset request wins over all.
module rt_ctrl
    import rt_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               stop_req,
    input  logic               tick,
    input  logic [DELAY_W-1:0] delay,
    output logic               led,
    output logic               clear,
    output logic               count_en
);

    rt_phase_t          phase_q, phase_d;
    logic [DELAY_W-1:0] remain_q;
    logic               wait_done;

    // A setting of 0 or 1 both end at the first tick
    assign wait_done = tick && (remain_q <= DELAY_W'(1));

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (!reset_req) phase_d = PH_WAIT;
            PH_WAIT: if (wait_done)  phase_d = PH_RUN;
            PH_RUN:  if (stop_req)   phase_d = PH_HALT;
            PH_HALT: phase_d = PH_HALT;
            default: phase_d = PH_IDLE;
        endcase
        if (reset_req) phase_d = PH_IDLE;
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Delay countdown: loaded while idle, one step per millisecond in wait
    always_ff @(posedge clk) begin
        if (!rst_n)                                   remain_q <= '0;
        else if (phase_q == PH_IDLE)                  remain_q <= delay;
        else if (phase_q == PH_WAIT && tick && remain_q != '0)
                                                      remain_q <= remain_q - 1'b1;
    end

    assign led      = (phase_q == PH_RUN);
    assign count_en = (phase_q == PH_RUN);
    assign clear    = (phase_q == PH_IDLE);

    // R1: a reset request always lands in idle
    assert_reset_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (phase_q == PH_IDLE));
    // R7: stop during the wait cannot reach the halt phase
    assert_stop_ignored_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT && !reset_req) |=> (phase_q != PH_HALT));
    // R5: stop while running halts on the next cycle
    assert_stop_halts_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN && stop_req && !reset_req) |=> (phase_q == PH_HALT));
    // R6: the halt phase is left only through a reset request
    assert_halt_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HALT && !reset_req) |=> (phase_q == PH_HALT));
    // R2: the countdown moves only on a tick
    assert_wait_steps_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT && !tick && !reset_req) |=> $stable(remain_q));

endmodule

// File: rtl/reaction_timer.sv
// Module: reaction_timer (top)
// Reaction timer: programmable wait, then an LED and a BCD millisecond
// count that a stop press freezes until the next reset press.
// Assumes: one clock; pushbuttons are active-low and asynchronous;
// CLK_PER_MS is the number of clock cycles in one millisecond.
module reaction_timer #(
    parameter int CLK_PER_MS  = 50000,
    parameter int DELAY_W     = 8,
    parameter int DIGITS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  btn_reset_n,
    input  logic                  btn_stop_n,
    input  logic [DELAY_W-1:0]    delay_ms,
    output logic                  led,
    output logic [4*DIGITS-1:0]   bcd_digits,
    output logic [7*DIGITS-1:0]   seg_out
);

    logic [1:0] btn_sync;
    logic       reset_req, stop_req;
    logic       ms_tick, clear, count_en;

    rt_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (2'b11)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({btn_stop_n, btn_reset_n}),
        .sync_out (btn_sync)
    );

    assign reset_req = !btn_sync[0];
    assign stop_req  = !btn_sync[1];

    rt_prescaler #(.DIV(CLK_PER_MS)) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .tick  (ms_tick)
    );

    rt_ctrl #(.DELAY_W(DELAY_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .stop_req  (stop_req),
        .tick      (ms_tick),
        .delay     (delay_ms),
        .led       (led),
        .clear     (clear),
        .count_en  (count_en)
    );

    rt_bcd_counter #(.DIGITS(DIGITS)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .step  (count_en && ms_tick),
        .value (bcd_digits)
    );

    rt_seg_bank #(.DIGITS(DIGITS)) u_seg (
        .bcd (bcd_digits),
        .seg (seg_out)
    );

    // R1: LED dark whenever the count is being cleared
    assert_idle_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !led);

endmodule

// File: tb/reaction_timer_bench.sv
// Directed bench for reaction_timer with a short millisecond (P cycles).
module reaction_timer_bench;

    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_reset_n = 1'b1;
    logic        btn_stop_n = 1'b1;
    logic [7:0]  delay_ms = 8'd0;
    logic        led;
    logic [15:0] bcd_digits;
    logic [27:0] seg_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    reaction_timer #(.CLK_PER_MS(P)) u_reaction_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_reset_n (btn_reset_n),
        .btn_stop_n  (btn_stop_n),
        .delay_ms    (delay_ms),
        .led         (led),
        .bcd_digits  (bcd_digits),
        .seg_out     (seg_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic logic [6:0] exp_seg(input logic [3:0] d);
        logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return t[d];
    endfunction

    function automatic logic [27:0] segs_for(input logic [15:0] b);
        return {exp_seg(b[15:12]), exp_seg(b[11:8]), exp_seg(b[7:4]), exp_seg(b[3:0])};
    endfunction

    // Hold the reset pushbutton for a few cycles
    task automatic press_reset();
        @(negedge clk) btn_reset_n = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Release reset, count edges until the LED lights; optional stop pulse
    task automatic release_and_time(input int d, input int stop_at, output int n);
        delay_ms = 8'(d);
        @(negedge clk) btn_reset_n = 1'b1;
        n = 0;
        while (n < 3 + 257 * P + 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == stop_at)     btn_stop_n = 1'b0;
            if (n == stop_at + 5) btn_stop_n = 1'b1;
            if (led) break;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(led == 1'b0, "R1 led in system reset", int'(led), 0);
        check(bcd_digits == 16'h0, "R1 digits in system reset", int'(bcd_digits), 0);
        rst_n = 1'b1;
        press_reset();
        check(led == 1'b0, "R1 led with reset held", int'(led), 0);
        check(bcd_digits == 16'h0, "R1 digits with reset held", int'(bcd_digits), 0);
        check(seg_out == segs_for(16'h0), "R9 segments for 0000", int'(seg_out), int'(segs_for(16'h0)));
    endtask

    task automatic t_delay(input int d, input string req);
        int n;
        int m;
        press_reset();
        release_and_time(d, -100, n);
        m = (d == 0) ? 1 : d;
        check(n == 3 + m * P, req, n, 3 + m * P);
        check(bcd_digits == 16'h0, "R4 count starts at 0000", int'(bcd_digits), 0);
    endtask

    // Run, stop after r milliseconds, check the frozen count
    task automatic t_measure(input int r);
        int n;
        press_reset();
        release_and_time(2, -100, n);
        repeat (P - 1) @(posedge clk);
        @(negedge clk);
        check(bcd_digits == 16'h0, "R4 no step before one ms", int'(bcd_digits), 0);
        @(posedge clk);
        @(negedge clk);
        check(bcd_digits == 16'h1, "R4 first step after one ms", int'(bcd_digits), 1);
        repeat (r * P - P) @(posedge clk);
        @(negedge clk) btn_stop_n = 1'b0;
        repeat (5) @(negedge clk);
        btn_stop_n = 1'b1;
        check(led == 1'b0, "R5 led off after stop", int'(led), 0);
        check(bcd_digits == to_bcd(r), "R5 frozen count", int'(bcd_digits), int'(to_bcd(r)));
        check(seg_out == segs_for(to_bcd(r)), "R9 segment patterns", int'(seg_out), int'(segs_for(to_bcd(r))));
    endtask

    task automatic t_hold(input int r);
        repeat (3) begin
            @(negedge clk) btn_stop_n = 1'b0;
            delay_ms = delay_ms + 8'd37;
            repeat (30) @(negedge clk);
            btn_stop_n = 1'b1;
            repeat (30) @(negedge clk);
        end
        check(bcd_digits == to_bcd(r), "R6 count held after stop", int'(bcd_digits), int'(to_bcd(r)));
        check(led == 1'b0, "R6 led stays off", int'(led), 0);
        press_reset();
        check(bcd_digits == 16'h0, "R6 reset clears frozen count", int'(bcd_digits), 0);
    endtask

    task automatic t_stop_in_wait();
        int n;
        press_reset();
        release_and_time(10, 8, n);
        check(n == 3 + 10 * P, "R7 stop in wait ignored", n, 3 + 10 * P);
        check(bcd_digits == 16'h0, "R7 count starts clean", int'(bcd_digits), 0);
        repeat (3 * P) @(negedge clk);
        check(led == 1'b1, "R7 still running", int'(led), 1);
    endtask

    task automatic t_saturate();
        int n;
        press_reset();
        release_and_time(1, -100, n);
        repeat (10100 * P) @(posedge clk);
        @(negedge clk);
        check(bcd_digits == 16'h9999, "R8 saturates at 9999", int'(bcd_digits), 16'h9999);
        check(led == 1'b1, "R8 led still on", int'(led), 1);
        check(seg_out == segs_for(16'h9999), "R9 segments for 9999", int'(seg_out), int'(segs_for(16'h9999)));
        @(negedge clk) btn_stop_n = 1'b0;
        repeat (5) @(negedge clk);
        btn_stop_n = 1'b1;
        check(bcd_digits == 16'h9999, "R8 freeze at 9999", int'(bcd_digits), 16'h9999);
    endtask

    initial begin
        t_reset_state();
        t_delay(5, "R2 delay 5");
        t_delay(1, "R2 delay 1");
        t_delay(0, "R3 delay 0");
        t_delay(255, "R2 delay 255");
        t_measure(7);
        t_hold(7);
        t_measure(123);
        t_stop_in_wait();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule